// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block watches the control pins of a four-bank SDRAM on every rising clock edge. It decodes the command carried by chip select, row strobe, column strobe, write enable and clock enable. It follows each bank through idle, open and self-closing states, and it checks the spacing between commands against minimum intervals. The intervals are given in nanoseconds and turned into cycle counts from the clock period. The block drives nothing towards the memory. It sits next to a controller or a memory model, and it reports the last decoded command, the state of every bank and a set of sticky violation flags.

Each rule that a command breaks sets its own flag. The code of the first violation seen is held alongside the flags until reset. A command that breaks a rule is still followed: the bank states move as the memory would move them, so that one fault does not bury the faults that come after it. The burst length used for self-closing accesses is taken from the low address bits whenever a mode load command is seen.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n high, cmd_o reports 0 (inhibit). With cs_n low, the pins {ras_n,cas_n,we_n} decode as 111=1 (no-op), 011=2 (activate), 101=3 (read), 100=4 (write), 110=5 (burst stop), 010=6 (precharge), 001=7 (auto refresh) or 8 (self refresh when cke is low), and 000=9 (mode load). cmd_o shows the command sampled at the previous rising edge.
- R2: Activate moves the addressed bank to state 1 (open). A read or write to a bank that is not in state 1 sets flag bit 0 (code 1). An activate to a bank that is not in state 0 (idle) sets flag bit 1 (code 2). Bank b is reported in bank_state_o[2b+1:2b].
- R3: Precharge with a10 high returns every bank to state 0 and ignores ba. Precharge with a10 low returns only bank ba to state 0.
- R4: A read or write with a10 high to an open bank puts that bank in state 2 (closing), and the bank becomes idle BL edges after the command. BL comes from addr_lo captured at the last mode load: 000=1, 001=2, 010=4, 011=8, other codes except 111 give 1. With code 111 (full page) the bank stays open. After reset the code is 000.
- R5: A mode load while any bank is not idle sets flag bit 2 (code 3). An auto or self refresh while any bank is not idle sets flag bit 3 (code 4).
- R6: With a 10 ns clock, a second command k edges after the first is flagged when k is below the limit: activate to read/write on that bank, limit 2, bit 4 (code 5); precharge or self-close completion to activate on that bank, limit 2, bit 5 (code 6); activate to precharge on that bank, limit 5, bit 6 (code 7); activate to activate on the same bank, limit 7, bit 7 (code 8); activate to activate on any bank, limit 2, bit 8 (code 9); mode load to activate or refresh, limit 2, bit 9 (code 10).
- R7: Flag bits stay set until reset. viol_code_o holds the code of the earliest violation, taking the lowest code among violations in the same cycle, and reads 0 while no flag is set.
- R8: After reset every bank is idle, cmd_o is 0, and all flags and the code are 0.
- R9: A violating command still updates bank state as R2 to R4 describe. A read or write to a bank that is not open leaves every bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low turns refresh into self refresh |
| ba | input | 2 | Bank address |
| a10 | input | 1 | All-banks select on precharge, self-close request on read or write |
| addr_lo | input | 3 | Low address bits; burst-length field on mode load |
| cmd_o | output | 4 | Decoded command of the previous edge |
| bank_state_o | output | 8 | Two-bit state per bank: 0 idle, 1 open, 2 closing |
| viol_flags_o | output | 10 | Sticky violation flags, bit i for code i+1 |
| viol_code_o | output | 4 | Code of the first violation, 0 when none |

## Verification
The bench builds the block with its default parameters: four banks, a 10 ns clock and the nanosecond limits of R6, which turn into limits of 2, 2, 5, 7, 2 and 2 cycles. These values are small enough to sweep every command gap from one cycle to just past each limit, to decode all 32 pin patterns, and to follow every burst-length code through a whole self-closing access cycle by cycle. Expected flags and codes come from comparing each gap with its limit.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_RD      = 4'd3,
        CMD_WR      = 4'd4,
        CMD_BST     = 4'd5,
        CMD_PRE     = 4'd6,
        CMD_REF     = 4'd7,
        CMD_SREF    = 4'd8,
        CMD_LMR     = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    localparam int NUM_CODES = 10;
    localparam int CODE_W    = 4;
    localparam int LEN_W     = 4;

    // flag bit positions; the reported code is position + 1
    localparam int VI_NOROW    = 0;
    localparam int VI_REOPEN   = 1;
    localparam int VI_LMR_BUSY = 2;
    localparam int VI_REF_BUSY = 3;
    localparam int VI_RCD      = 4;
    localparam int VI_RP       = 5;
    localparam int VI_RAS      = 6;
    localparam int VI_RC       = 7;
    localparam int VI_RRD      = 8;
    localparam int VI_MRD      = 9;

    typedef struct packed {
        logic no_row;
        logic reopen;
        logic rcd;
        logic rp;
        logic ras;
        logic rc;
    } bank_viol_t;

    function automatic int cyc_from_ns(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n,
                                         input logic cke);
        cmd_e c;
        if (cs_n) begin
            c = CMD_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = CMD_PRE;
                3'b001:  c = cke ? CMD_REF : CMD_SREF;
                default: c = CMD_LMR;
            endcase
        end
        return c;
    endfunction

    function automatic logic [LEN_W-1:0] burst_len(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'b001:  n = LEN_W'(2);
            3'b010:  n = LEN_W'(4);
            3'b011:  n = LEN_W'(8);
            default: n = LEN_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sdmon_cmd_decode.sv
module sdmon_cmd_decode
    import sdmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd_now,
    output cmd_e cmd_q
);

    always_comb begin
        cmd_now = decode_pins(cs_n, ras_n, cas_n, we_n, cke);
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= CMD_INHIBIT;
        else     cmd_q <= cmd_now;
    end

    p_inhibit_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_q == CMD_INHIBIT));

    p_selfref_r1: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && we_n && !cke) |=> (cmd_q == CMD_SREF));

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int RCD_C = 2,
    parameter int RP_C  = 2,
    parameter int RAS_C = 5,
    parameter int RC_C  = 7,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic             a10,
    input  logic [LEN_W-1:0] ap_len,
    input  logic             full_page,
    output bank_st_e         state_o,
    output bank_viol_t       viol_o
);

    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(RCD_C - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_C - 1);
    localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(RAS_C - 1);
    localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(RC_C - 1);

    bank_st_e         state_q;
    logic [LEN_W-1:0] ap_cnt;
    logic [CNT_W-1:0] rcd_cnt, rp_cnt, ras_cnt, rc_cnt;
    logic             hit_act, hit_rw, hit_pre, start_close;

    always_comb begin
        hit_act     = (cmd == CMD_ACT) && sel;
        hit_rw      = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
        hit_pre     = (cmd == CMD_PRE) && (a10 || sel);
        start_close = hit_rw && (state_q == BK_OPEN) && a10 && !full_page;

        viol_o.no_row = hit_rw  && (state_q != BK_OPEN);
        viol_o.reopen = hit_act && (state_q != BK_IDLE);
        viol_o.rcd    = hit_rw  && (rcd_cnt != '0);
        viol_o.rp     = hit_act && (rp_cnt  != '0);
        viol_o.ras    = hit_pre && (state_q != BK_IDLE) && (ras_cnt != '0);
        viol_o.rc     = hit_act && (rc_cnt  != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            ap_cnt  <= '0;
            rcd_cnt <= '0;
            rp_cnt  <= '0;
            ras_cnt <= '0;
            rc_cnt  <= '0;
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (rp_cnt  != '0) rp_cnt  <= rp_cnt  - 1'b1;
            if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
            if (rc_cnt  != '0) rc_cnt  <= rc_cnt  - 1'b1;
            if (ap_cnt  != '0) ap_cnt  <= ap_cnt  - 1'b1;

            if (hit_act) begin
                state_q <= BK_OPEN;
                rcd_cnt <= RCD_LD;
                ras_cnt <= RAS_LD;
                rc_cnt  <= RC_LD;
            end else if (hit_pre) begin
                state_q <= BK_IDLE;
                rp_cnt  <= RP_LD;
            end else if (start_close) begin
                state_q <= BK_CLOSING;
                ap_cnt  <= ap_len - LEN_W'(1);
            end else if ((state_q == BK_CLOSING) && (ap_cnt == '0)) begin
                state_q <= BK_IDLE;
                rp_cnt  <= RP_LD;
            end
        end
    end

    assign state_o = state_q;

    p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
        hit_act |=> (state_q == BK_OPEN));

    p_pre_closes_r3: assert property (@(posedge clk) disable iff (rst)
        hit_pre |=> (state_q == BK_IDLE));

    p_rc_window_r6: assert property (@(posedge clk) disable iff (rst)
        (rc_cnt <= RC_LD) && (rp_cnt <= RP_LD));

    p_close_from_open_r4: assert property (@(posedge clk) disable iff (rst)
        ((state_q != BK_CLOSING) && !start_close) |=> (state_q != BK_CLOSING));

endmodule

// File: rtl/sdmon_viol_log.sv
module sdmon_viol_log
    import sdmon_pkg::*;
#(
    parameter int N = NUM_CODES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      events,
    output logic [N-1:0]      flags_o,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] first_code;

    always_comb begin
        first_code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (events[i]) first_code = CODE_W'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
            code_o  <= '0;
        end else begin
            flags_o <= flags_o | events;
            if (code_o == '0) code_o <= first_code;
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & $past(flags_o)) == $past(flags_o)));

    p_code_matches_flags_r7: assert property (@(posedge clk) disable iff (rst)
        ((code_o != '0) == (flags_o != '0)));

    p_code_held_r7: assert property (@(posedge clk) disable iff (rst)
        (code_o != '0) |=> $stable(code_o));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdmon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_NS    = 10,
    parameter int T_RCD_NS  = 20,
    parameter int T_RP_NS   = 20,
    parameter int T_RAS_NS  = 50,
    parameter int T_RC_NS   = 70,
    parameter int T_RRD_NS  = 15,
    parameter int T_MRD_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [1:0]             ba,
    input  logic                   a10,
    input  logic [2:0]             addr_lo,
    output logic [3:0]             cmd_o,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic [NUM_CODES-1:0]   viol_flags_o,
    output logic [CODE_W-1:0]      viol_code_o
);

    localparam int BA_W  = 2;
    localparam int RCD_C = cyc_from_ns(T_RCD_NS, CLK_NS);
    localparam int RP_C  = cyc_from_ns(T_RP_NS, CLK_NS);
    localparam int RAS_C = cyc_from_ns(T_RAS_NS, CLK_NS);
    localparam int RC_C  = cyc_from_ns(T_RC_NS, CLK_NS);
    localparam int RRD_C = cyc_from_ns(T_RRD_NS, CLK_NS);
    localparam int BK_MAX = max_int(max_int(RCD_C, RP_C), max_int(RAS_C, RC_C));
    localparam int CNT_W  = $clog2(BK_MAX + 1);
    localparam int G_MAX  = max_int(RRD_C, T_MRD_CYC);
    localparam int GCW    = $clog2(G_MAX + 1);
    localparam logic [GCW-1:0] RRD_LD = GCW'(RRD_C - 1);
    localparam logic [GCW-1:0] MRD_LD = GCW'(T_MRD_CYC - 1);

    cmd_e             cmd_now, cmd_q;
    logic [2:0]       mode_bl_q;
    logic [LEN_W-1:0] ap_len;
    logic             full_page;
    logic [GCW-1:0]   rrd_cnt, mrd_cnt;
    bank_st_e         st   [NUM_BANKS];
    bank_viol_t       bviol[NUM_BANKS];
    logic [NUM_CODES-1:0] events;
    logic             busy_any, is_ref;

    sdmon_cmd_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cke     (cke),
        .cmd_now (cmd_now),
        .cmd_q   (cmd_q)
    );

    always_comb begin
        ap_len    = burst_len(mode_bl_q);
        full_page = (mode_bl_q == 3'b111);
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdmon_bank #(
            .RCD_C (RCD_C),
            .RP_C  (RP_C),
            .RAS_C (RAS_C),
            .RC_C  (RC_C),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd_now),
            .sel       (ba == BA_W'(g)),
            .a10       (a10),
            .ap_len    (ap_len),
            .full_page (full_page),
            .state_o   (st[g]),
            .viol_o    (bviol[g])
        );
        assign bank_state_o[2*g +: 2] = st[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_bl_q <= 3'b000;
            rrd_cnt   <= '0;
            mrd_cnt   <= '0;
        end else begin
            if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - 1'b1;
            if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
            if (cmd_now == CMD_ACT) rrd_cnt <= RRD_LD;
            if (cmd_now == CMD_LMR) begin
                mrd_cnt   <= MRD_LD;
                mode_bl_q <= addr_lo;
            end
        end
    end

    always_comb begin
        busy_any = 1'b0;
        events   = '0;
        is_ref   = (cmd_now == CMD_REF) || (cmd_now == CMD_SREF);
        for (int b = 0; b < NUM_BANKS; b++) begin
            busy_any            = busy_any | (st[b] != BK_IDLE);
            events[VI_NOROW]    = events[VI_NOROW]  | bviol[b].no_row;
            events[VI_REOPEN]   = events[VI_REOPEN] | bviol[b].reopen;
            events[VI_RCD]      = events[VI_RCD]    | bviol[b].rcd;
            events[VI_RP]       = events[VI_RP]     | bviol[b].rp;
            events[VI_RAS]      = events[VI_RAS]    | bviol[b].ras;
            events[VI_RC]       = events[VI_RC]     | bviol[b].rc;
        end
        events[VI_LMR_BUSY] = (cmd_now == CMD_LMR) && busy_any;
        events[VI_REF_BUSY] = is_ref && busy_any;
        events[VI_RRD]      = (cmd_now == CMD_ACT) && (rrd_cnt != '0);
        events[VI_MRD]      = ((cmd_now == CMD_ACT) || is_ref) && (mrd_cnt != '0);
    end

    sdmon_viol_log #(.N(NUM_CODES)) u_log (
        .clk     (clk),
        .rst     (rst),
        .events  (events),
        .flags_o (viol_flags_o),
        .code_o  (viol_code_o)
    );

    assign cmd_o = cmd_q;

    p_rw_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (((cmd_now == CMD_RD) || (cmd_now == CMD_WR)) && (st[ba] == BK_IDLE))
        |=> viol_flags_o[VI_NOROW]);

    p_lmr_busy_r5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_now == CMD_LMR) && (bank_state_o != '0)) |=> viol_flags_o[VI_LMR_BUSY]);

    p_mrd_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ((cmd_now == CMD_LMR) ##1 (cmd_now == CMD_ACT)) |=> viol_flags_o[VI_MRD]);

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam int C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4, C_PRE = 6,
                   C_REF = 7, C_SREF = 8, C_LMR = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0] ba = 2'd0;
    logic a10 = 1'b0;
    logic [2:0] addr_lo = 3'd0;
    logic [3:0] cmd_o;
    logic [7:0] bank_state_o;
    logic [9:0] viol_flags_o;
    logic [3:0] viol_code_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .ba (ba), .a10 (a10), .addr_lo (addr_lo),
        .cmd_o (cmd_o), .bank_state_o (bank_state_o),
        .viol_flags_o (viol_flags_o), .viol_code_o (viol_code_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bstate(input int b);
        return int'((bank_state_o >> (2*b)) & 8'd3);
    endfunction

    task automatic drive(input int c, input int bank, input bit ap, input int lo);
        cs_n = 1'b0; cke = 1'b1;
        ba = 2'(bank); a10 = ap; addr_lo = 3'(lo);
        case (c)
            C_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            C_RD:   {ras_n, cas_n, we_n} = 3'b101;
            C_WR:   {ras_n, cas_n, we_n} = 3'b100;
            C_PRE:  {ras_n, cas_n, we_n} = 3'b010;
            C_REF:  {ras_n, cas_n, we_n} = 3'b001;
            C_SREF: begin {ras_n, cas_n, we_n} = 3'b001; cke = 1'b0; end
            C_LMR:  {ras_n, cas_n, we_n} = 3'b000;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    endtask

    task automatic send(input int c, input int bank, input bit ap, input int lo);
        drive(c, bank, ap, lo);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(C_NOP, 0, 1'b0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(C_NOP, 0, 1'b0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int exp_decode(input int v);
        int rcw;
        if (v[4]) return 0;
        rcw = (v >> 1) & 7;
        case (rcw)
            7: return 1;
            3: return 2;
            5: return 3;
            4: return 4;
            6: return 5;
            2: return 6;
            1: return v[0] ? 7 : 8;
            default: return 9;
        endcase
    endfunction

    task automatic pair_gap(input int c1, input int b1, input int c2, input int b2,
                            input int k, input int bit_idx, input int need,
                            input string req);
        int ef;
        do_reset();
        send(c1, b1, 1'b0, 0);
        idle(k - 1);
        send(c2, b2, 1'b0, 0);
        ef = (k < need) ? (1 << bit_idx) : 0;
        check(req, int'(viol_flags_o), ef);
        check(req, int'(viol_code_o), (k < need) ? bit_idx + 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: reset state
        check("R8 cmd", int'(cmd_o), 0);
        check("R8 banks", int'(bank_state_o), 0);
        check("R8 flags", int'(viol_flags_o), 0);
        check("R8 code", int'(viol_code_o), 0);

        // R1: all pin patterns
        for (int v = 0; v < 32; v++) begin
            cs_n = v[4]; ras_n = v[3]; cas_n = v[2]; we_n = v[1]; cke = v[0];
            @(posedge clk);
            @(negedge clk);
            check("R1 decode", int'(cmd_o), exp_decode(v));
        end

        // R2 / R9: read to idle bank
        do_reset();
        send(C_RD, 1, 1'b0, 0);
        check("R2 norow flags", int'(viol_flags_o), 1);
        check("R2 norow code", int'(viol_code_o), 1);
        check("R9 state kept", int'(bank_state_o), 0);
        // R2 / R9: activate an open bank
        do_reset();
        send(C_ACT, 2, 1'b0, 0);
        check("R2 open", bstate(2), 1);
        idle(7);
        send(C_ACT, 2, 1'b0, 0);
        check("R2 reopen flags", int'(viol_flags_o), 2);
        check("R2 reopen code", int'(viol_code_o), 2);
        check("R9 still open", int'(bank_state_o), 16);

        // R3: per-bank and all-bank precharge
        do_reset();
        for (int b = 0; b < 4; b++) begin
            send(C_ACT, b, 1'b0, 0);
            idle(1);
        end
        idle(5);
        send(C_PRE, 1, 1'b0, 0);
        check("R3 single", int'(bank_state_o), 81);
        send(C_PRE, 1, 1'b1, 0);
        check("R3 all", int'(bank_state_o), 0);
        check("R3 clean", int'(viol_flags_o), 0);

        // R4: self-closing access over burst-length codes
        for (int t = 0; t < 6; t++) begin
            int code, len;
            code = (t == 4) ? 7 : ((t == 5) ? 4 : t);
            len  = (t == 4) ? 0 : ((t == 5) ? 1 : (1 << t));
            do_reset();
            send(C_LMR, 0, 1'b0, code);
            idle(1);
            send(C_ACT, 2, 1'b0, 0);
            idle(1);
            send(C_WR, 2, 1'b1, 0);
            for (int j = 0; j < 10; j++) begin
                check("R4 close state", bstate(2), (len == 0) ? 1 : ((j < len) ? 2 : 0));
                send(C_NOP, 0, 1'b0, 0);
            end
            check("R4 clean", int'(viol_flags_o), 0);
        end

        // R4 / R6: activate after self-close completion
        for (int k = 1; k <= 3; k++) begin
            do_reset();
            send(C_ACT, 2, 1'b0, 0);
            idle(6);
            send(C_RD, 2, 1'b1, 0);
            idle(k - 1);
            send(C_ACT, 2, 1'b0, 0);
            check("R6 close-to-act", int'(viol_flags_o), (k == 1) ? 2 : ((k == 2) ? 32 : 0));
        end

        // R5: mode load and refresh with an open bank
        do_reset();
        send(C_LMR, 0, 1'b0, 0);
        check("R5 lmr idle ok", int'(viol_flags_o), 0);
        do_reset();
        send(C_ACT, 0, 1'b0, 0);
        idle(7);
        send(C_LMR, 0, 1'b0, 0);
        check("R5 lmr busy", int'(viol_flags_o), 4);
        check("R5 lmr code", int'(viol_code_o), 3);
        do_reset();
        send(C_ACT, 3, 1'b0, 0);
        idle(7);
        send(C_REF, 0, 1'b0, 0);
        check("R5 ref busy", int'(viol_flags_o), 8);
        check("R5 ref code", int'(viol_code_o), 4);
        do_reset();
        send(C_ACT, 1, 1'b0, 0);
        idle(7);
        send(C_SREF, 0, 1'b0, 0);
        check("R5 sref busy", int'(viol_flags_o), 8);

        // R6: interval sweeps
        for (int k = 1; k <= 8; k++) begin
            pair_gap(C_ACT, 0, C_RD,  0, k, 4, 2, "R6 act-rw");
            pair_gap(C_ACT, 0, C_PRE, 0, k, 6, 5, "R6 act-pre");
            pair_gap(C_ACT, 0, C_ACT, 1, k, 8, 2, "R6 act-act any");
            pair_gap(C_LMR, 0, C_ACT, 0, k, 9, 2, "R6 lmr-act");
            pair_gap(C_LMR, 0, C_REF, 0, k, 9, 2, "R6 lmr-ref");
        end
        for (int k = 1; k <= 4; k++) begin
            do_reset();
            send(C_ACT, 0, 1'b0, 0);
            idle(7);
            send(C_PRE, 0, 1'b0, 0);
            idle(k - 1);
            send(C_ACT, 0, 1'b0, 0);
            check("R6 pre-act", int'(viol_flags_o), (k < 2) ? 32 : 0);
        end
        for (int k = 6; k <= 9; k++) begin
            int ef;
            do_reset();
            send(C_ACT, 0, 1'b0, 0);
            idle(4);
            send(C_PRE, 0, 1'b0, 0);
            idle(k - 6);
            send(C_ACT, 0, 1'b0, 0);
            ef = ((k < 7) ? 128 : 0) | (((k - 5) < 2) ? 32 : 0);
            check("R6 act-act same", int'(viol_flags_o), ef);
            check("R6 act-act code", int'(viol_code_o), (k == 6) ? 6 : 0);
        end

        // R7: sticky flags, first code kept
        do_reset();
        send(C_ACT, 0, 1'b0, 0);
        idle(2);
        send(C_RD, 1, 1'b0, 0);
        idle(1);
        send(C_LMR, 0, 1'b0, 0);
        check("R7 flags", int'(viol_flags_o), 5);
        check("R7 first code", int'(viol_code_o), 1);
        idle(3);
        check("R7 sticky", int'(viol_flags_o), 5);
        check("R7 code held", int'(viol_code_o), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule